// File: doc/BRIEF.md
# Iterative Integer Multiplier with Overflow Detection

The block multiplies two integers of a parameterised width (32 bits by default). It works sequentially, one shift-and-add step per clock. A single start pulse launches an operation. A 3-bit mode code chooses one of several result forms:

- a full double-width product, signed or unsigned, split into a high and a low word;
- a single-word truncated product that reports no overflow;
- a single-word product whose overflow flag is judged under signed rules;
- a single-word product whose overflow flag is judged under unsigned rules.

The second operand is either the `src_b` register input or a narrow immediate. The immediate is widened to match the signedness of the selected mode.

Signed operands are converted to magnitudes before the multiply. The unsigned shift-and-add core forms the product over WIDTH cycles, and the sign is restored at the end. The controller has three states:

- IDLE waits for `start`. IDLE→CALC fires on `start` and latches the operands, the mode and the result sign.
- CALC runs one step per cycle. CALC→CALC repeats while the step counter is below WIDTH-1. CALC→FINISH fires on the last step.
- FINISH registers hi, lo and the overflow flag and raises `done`. FINISH→IDLE is unconditional.

The result outputs hold their values until the next operation finishes.

Top module: `mul_ovf_unit`

## Requirements
- R1: While reset is held and after its release, `done`, `ovf`, `hi` and `lo` are all zero until the first operation completes.
- R2: Mode code 0 (full signed) gives the two's complement double-width product of signed operands: `hi` holds product bits 63..32 and `lo` holds bits 31..0.
- R3: Mode code 1 (full unsigned) gives the double-width product of both operands taken as unsigned, with `hi` holding the upper word and `lo` the lower.
- R4: Mode code 2 (low word, unchecked) returns the low 32 bits of the product in `lo` with `ovf` at 0. Reserved codes 5, 6 and 7 behave exactly like code 2.
- R5: Mode code 3 (low word, signed check) returns the low word in `lo`. It sets `ovf` when the upper 32 product bits are not all copies of product bit 31.
- R6: Mode code 4 (low word, unsigned check) returns the low word of the unsigned product in `lo`. It sets `ovf` when any of the upper 32 product bits is 1.
- R7: With `use_imm` at 1, the 16-bit `imm` replaces `src_b` and `src_b` has no effect. The immediate is zero-extended in codes 1 and 4 and sign-extended in all other codes.
- R8: Full modes never raise `ovf`. In every single-word mode, `hi` reads zero.
- R9: `done` is high for exactly one cycle. It rises WIDTH+2 clock edges after the edge that samples `start`, counting that edge.
- R10: A `start` pulse that arrives while an operation is in progress is ignored. The running operation completes with its original operands and mode.
- R11: `hi`, `lo` and `ovf` hold their values from one `done` pulse until the next. A `start` given in the cycle where `done` is high is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launches an operation when the controller is idle |
| mode | input | 3 | Result form code (see R2 to R6) |
| src_a | input | WIDTH | First operand (multiplicand) |
| src_b | input | WIDTH | Second operand from a register |
| use_imm | input | 1 | Selects `imm` in place of `src_b` |
| imm | input | IMM_W | Immediate second operand |
| hi | output | WIDTH | Upper product word in full modes, zero otherwise |
| lo | output | WIDTH | Lower product word |
| done | output | 1 | One-cycle pulse when a result is valid |
| ovf | output | 1 | Overflow flag of a checked single-word mode |

## Verification
Two events can fall in the same cycle: the `done` pulse of one result and the acceptance of the next `start`. The bench provokes this by raising `start` in exactly the cycle where it first sees `done` high. On every following cycle before the next `done`, it confirms that `hi`, `lo` and `ovf` still show the first result. It then checks the second result and its latency against the reference model. A second overlap test sends a `start` in the middle of a calculation and expects the result of the first operation only.

// File: rtl/mul_ovf_pkg.sv
package mul_ovf_pkg;

    typedef enum logic [2:0] {
        MD_FULL_S    = 3'd0,
        MD_FULL_U    = 3'd1,
        MD_LOW_RAW   = 3'd2,
        MD_LOW_CHK_S = 3'd3,
        MD_LOW_CHK_U = 3'd4
    } mul_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_CALC   = 2'd1,
        ST_FINISH = 2'd2
    } mul_state_e;

    // Operands are treated as unsigned only in the two unsigned codes
    function automatic logic mode_is_signed(input logic [2:0] m);
        return !((m == MD_FULL_U) || (m == MD_LOW_CHK_U));
    endfunction

    function automatic logic mode_is_full(input logic [2:0] m);
        return (m == MD_FULL_S) || (m == MD_FULL_U);
    endfunction

endpackage

// File: rtl/mul_ovf_opsel.sv
module mul_ovf_opsel
    import mul_ovf_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16
) (
    input  logic [2:0]       mode,
    input  logic [WIDTH-1:0] src_a,
    input  logic [WIDTH-1:0] src_b,
    input  logic             use_imm,
    input  logic [IMM_W-1:0] imm,
    output logic [WIDTH-1:0] mag_a,
    output logic [WIDTH-1:0] mag_b,
    output logic             neg_res
);

    localparam int EXT_W = WIDTH - IMM_W;

    logic             sgn;
    logic [WIDTH-1:0] opnd_b;
    logic             neg_a;
    logic             neg_b;

    assign sgn = mode_is_signed(mode);

    // Immediate widened to the signedness of the selected mode
    always_comb begin
        if (use_imm) begin
            if (sgn) opnd_b = {{EXT_W{imm[IMM_W-1]}}, imm};
            else     opnd_b = {{EXT_W{1'b0}}, imm};
        end else begin
            opnd_b = src_b;
        end
    end

    // Magnitudes feed the unsigned core; the most negative value maps to 2^(W-1)
    assign neg_a   = sgn & src_a[WIDTH-1];
    assign neg_b   = sgn & opnd_b[WIDTH-1];
    assign mag_a   = neg_a ? (-src_a) : src_a;
    assign mag_b   = neg_b ? (-opnd_b) : opnd_b;
    assign neg_res = neg_a ^ neg_b;

endmodule

// File: rtl/mul_ovf_shiftadd.sv
module mul_ovf_shiftadd #(
    parameter int WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic [WIDTH-1:0]   mag_a,
    input  logic [WIDTH-1:0]   mag_b,
    output logic [2*WIDTH-1:0] prod
);

    logic [WIDTH-1:0] mcand;
    logic [WIDTH:0]   partial;

    // Add the multiplicand into the upper half when the current multiplier bit is set
    always_comb begin
        partial = {1'b0, prod[2*WIDTH-1:WIDTH]} + (prod[0] ? {1'b0, mcand} : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand <= '0;
            prod  <= '0;
        end else if (load) begin
            mcand <= mag_a;
            prod  <= {{WIDTH{1'b0}}, mag_b};
        end else if (step) begin
            prod  <= {partial, prod[WIDTH-1:1]};
        end
    end

    AST_LOAD_STEP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && step)); // R10

endmodule

// File: rtl/mul_ovf_fmt.sv
module mul_ovf_fmt
    import mul_ovf_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [2:0]         mode,
    input  logic               neg,
    input  logic [2*WIDTH-1:0] prod,
    output logic [WIDTH-1:0]   res_hi,
    output logic [WIDTH-1:0]   res_lo,
    output logic               res_ovf
);

    logic [2*WIDTH-1:0] full;
    logic [WIDTH-1:0]   upper;

    assign full  = neg ? (-prod) : prod;
    assign upper = full[2*WIDTH-1:WIDTH];

    always_comb begin
        unique case (mode)
            MD_LOW_CHK_S: res_ovf = (upper != {WIDTH{full[WIDTH-1]}});
            MD_LOW_CHK_U: res_ovf = |upper;
            default:      res_ovf = 1'b0;
        endcase
    end

    assign res_hi = mode_is_full(mode) ? upper : '0;
    assign res_lo = full[WIDTH-1:0];

    // An unsigned mode never carries a negative sign from operand selection
    always_comb begin
        AST_UNSIGNED_NO_NEG: assert (!((mode == MD_LOW_CHK_U || mode == MD_FULL_U) && neg)); // R6
    end

endmodule

// File: rtl/mul_ovf_unit.sv
module mul_ovf_unit
    import mul_ovf_pkg::*;
#(
    parameter int WIDTH = 32,
    parameter int IMM_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       mode,
    input  logic [WIDTH-1:0] src_a,
    input  logic [WIDTH-1:0] src_b,
    input  logic             use_imm,
    input  logic [IMM_W-1:0] imm,
    output logic [WIDTH-1:0] hi,
    output logic [WIDTH-1:0] lo,
    output logic             done,
    output logic             ovf
);

    localparam int CNT_W = $clog2(WIDTH);
    localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

    mul_state_e         state;
    mul_state_e         state_nx;
    logic [CNT_W-1:0]   cnt;
    logic [2:0]         mode_q;
    logic               neg_q;
    logic               load;
    logic               step;
    logic [WIDTH-1:0]   mag_a;
    logic [WIDTH-1:0]   mag_b;
    logic               neg_res;
    logic [2*WIDTH-1:0] prod;
    logic [WIDTH-1:0]   res_hi;
    logic [WIDTH-1:0]   res_lo;
    logic               res_ovf;

    mul_ovf_opsel #(.WIDTH(WIDTH), .IMM_W(IMM_W)) opsel_i (
        .mode    (mode),
        .src_a   (src_a),
        .src_b   (src_b),
        .use_imm (use_imm),
        .imm     (imm),
        .mag_a   (mag_a),
        .mag_b   (mag_b),
        .neg_res (neg_res)
    );

    mul_ovf_shiftadd #(.WIDTH(WIDTH)) core_i (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .step  (step),
        .mag_a (mag_a),
        .mag_b (mag_b),
        .prod  (prod)
    );

    mul_ovf_fmt #(.WIDTH(WIDTH)) fmt_i (
        .mode    (mode_q),
        .neg     (neg_q),
        .prod    (prod),
        .res_hi  (res_hi),
        .res_lo  (res_lo),
        .res_ovf (res_ovf)
    );

    assign load = (state == ST_IDLE) && start;
    assign step = (state == ST_CALC);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (start) state_nx = ST_CALC;
            ST_CALC:   if (cnt == LAST_STEP) state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Step counter and per-operation context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            mode_q <= 3'd0;
            neg_q  <= 1'b0;
        end else if (load) begin
            cnt    <= '0;
            mode_q <= mode;
            neg_q  <= neg_res;
        end else if (step) begin
            cnt    <= cnt + CNT_W'(1);
        end
    end

    // Outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi   <= '0;
            lo   <= '0;
            ovf  <= 1'b0;
            done <= 1'b0;
        end else if (state == ST_FINISH) begin
            hi   <= res_hi;
            lo   <= res_lo;
            ovf  <= res_ovf;
            done <= 1'b1;
        end else begin
            done <= 1'b0;
        end
    end

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CALC && cnt != LAST_STEP) |=> (state == ST_CALC && cnt == $past(cnt) + CNT_W'(1))); // R9
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(hi) && $stable(lo) && $stable(ovf))); // R11
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CALC) |=> ($stable(mode_q) && $stable(neg_q))); // R10
    AST_FULL_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_is_full(mode_q)) |-> !ovf); // R8
    AST_RAW_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode_q != MD_LOW_CHK_S && mode_q != MD_LOW_CHK_U) |-> !ovf); // R4
    AST_LOW_HI_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !mode_is_full(mode_q)) |-> (hi == '0)); // R8

endmodule

// File: tb/mul_ovf_unit_tb_top.sv
module mul_ovf_unit_tb_top;

    localparam int LATENCY = 34;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start;
    logic [2:0]  mode;
    logic [31:0] src_a;
    logic [31:0] src_b;
    logic        use_imm;
    logic [15:0] imm;
    logic [31:0] hi;
    logic [31:0] lo;
    logic        done;
    logic        ovf;

    int checks   = 0;
    int failures = 0;

    always #10 clk = ~clk;

    mul_ovf_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .src_a(src_a), .src_b(src_b), .use_imm(use_imm), .imm(imm),
        .hi(hi), .lo(lo), .done(done), .ovf(ovf)
    );

    // Reference model built from the requirements
    task automatic ref_mul(input logic [2:0] m, input logic [31:0] a, input logic [31:0] b,
                           input logic ui, input logic [15:0] im,
                           output logic [31:0] eh, output logic [31:0] el, output logic eo);
        logic        sgn;
        logic [31:0] bb;
        logic [63:0] p;
        sgn = !(m == 3'd1 || m == 3'd4);
        bb  = ui ? (sgn ? {{16{im[15]}}, im} : {16'h0, im}) : b;
        if (sgn) p = $signed({{32{a[31]}}, a}) * $signed({{32{bb[31]}}, bb});
        else     p = {32'h0, a} * {32'h0, bb};
        el = p[31:0];
        eh = (m == 3'd0 || m == 3'd1) ? p[63:32] : 32'h0;
        if (m == 3'd3)      eo = (p[63:32] != {32{p[31]}});
        else if (m == 3'd4) eo = (p[63:32] != 32'h0);
        else                eo = 1'b0;
    endtask

    function automatic string tag_of(input logic [2:0] m, input logic ui);
        string t;
        case (m)
            3'd0: t = "R2";
            3'd1: t = "R3";
            3'd3: t = "R5";
            3'd4: t = "R6";
            default: t = "R4";
        endcase
        return ui ? {t, "/R7"} : t;
    endfunction

    task automatic check_res(input string tag, input logic [31:0] eh, input logic [31:0] el, input logic eo);
        checks++;
        if (hi !== eh || lo !== el || ovf !== eo) begin
            failures++;
            $display("FAIL %s: hi=%h lo=%h ovf=%b expected hi=%h lo=%h ovf=%b", tag, hi, lo, ovf, eh, el, eo);
        end
    endtask

    task automatic check_int(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at a negedge: presents an operation with start high
    task automatic issue(input logic [2:0] m, input logic [31:0] a, input logic [31:0] b,
                         input logic ui, input logic [15:0] im);
        mode = m; src_a = a; src_b = b; use_imm = ui; imm = im; start = 1'b1;
    endtask

    // Counts negedges until done is seen; optionally watches that outputs hold
    task automatic wait_done(output int lat, input logic watch, input logic [31:0] wh,
                             input logic [31:0] wl, input logic wo, output logic hold_bad);
        lat = 0;
        hold_bad = 1'b0;
        do begin
            @(negedge clk);
            start = 1'b0;
            lat++;
            if (watch && !done && (hi !== wh || lo !== wl || ovf !== wo)) hold_bad = 1'b1;
        end while (!done && lat < 100);
    endtask

    task automatic run_op(input logic [2:0] m, input logic [31:0] a, input logic [31:0] b,
                          input logic ui, input logic [15:0] im);
        logic [31:0] eh, el;
        logic        eo, hb;
        int          lat;
        ref_mul(m, a, b, ui, im, eh, el, eo);
        issue(m, a, b, ui, im);
        wait_done(lat, 1'b0, '0, '0, 1'b0, hb);
        check_int("R9 latency", lat, LATENCY);
        check_res(tag_of(m, ui), eh, el, eo);
        src_b = ~src_b; // src_b changes after launch must not matter
        @(negedge clk);
        check_int("R9 done width", int'(done), 0);
    endtask

    function automatic logic [31:0] pick();
        case ($urandom % 7)
            0: return 32'h8000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'h7FFF_FFFF;
            3: return $urandom % 256;
            4: return -($urandom % 70000);
            5: return $urandom % 70000;
            default: return $urandom;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [31:0] eh, el, ch, cl;
        logic        eo, co, hb;
        int          lat;
        void'($urandom(32'd2024));
        rst_n = 1'b0; start = 1'b0; mode = 3'd0; src_a = '0; src_b = '0; use_imm = 1'b0; imm = '0;
        repeat (4) @(negedge clk);
        check_res("R1 in reset", 32'h0, 32'h0, 1'b0);
        check_int("R1 done in reset", int'(done), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check_res("R1 after reset", 32'h0, 32'h0, 1'b0);

        // Directed corners
        run_op(3'd0, 32'h8000_0000, 32'h8000_0000, 1'b0, 16'h0);  // R2
        run_op(3'd0, 32'hFFFF_FFFD, 32'h0000_0007, 1'b0, 16'h0);  // R2
        run_op(3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b0, 16'h0);  // R3
        run_op(3'd2, 32'h0001_0000, 32'h0001_0000, 1'b0, 16'h0);  // R4 R8
        run_op(3'd7, 32'h1234_5678, 32'h9ABC_DEF0, 1'b0, 16'h0);  // R4 reserved code
        run_op(3'd3, 32'h0001_0000, 32'h0000_8000, 1'b0, 16'h0);  // R5 overflow
        run_op(3'd3, 32'hFFFF_0000, 32'h0000_8000, 1'b0, 16'h0);  // R5 exact fit
        run_op(3'd4, 32'h0001_0000, 32'h0001_0000, 1'b0, 16'h0);  // R6 overflow
        run_op(3'd4, 32'h0000_FFFF, 32'h0001_0001, 1'b0, 16'h0);  // R6 fits
        run_op(3'd0, 32'h0000_0003, 32'hDEAD_BEEF, 1'b1, 16'hFFFF); // R7 sign-extend
        run_op(3'd1, 32'h0000_0003, 32'hDEAD_BEEF, 1'b1, 16'hFFFF); // R7 zero-extend
        run_op(3'd4, 32'h0001_0000, 32'h0000_0001, 1'b1, 16'h8000); // R7 unsigned imm

        // R10: start during calculation is ignored
        ref_mul(3'd1, 32'h0000_1111, 32'h0000_2222, 1'b0, 16'h0, eh, el, eo);
        issue(3'd1, 32'h0000_1111, 32'h0000_2222, 1'b0, 16'h0);
        @(negedge clk); start = 1'b0;
        repeat (4) @(negedge clk);
        issue(3'd3, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b0, 16'h0);
        wait_done(lat, 1'b0, '0, '0, 1'b0, hb);
        check_int("R10 latency of first op", lat, LATENCY - 5);
        check_res("R10 busy start ignored", eh, el, eo);
        @(negedge clk);
        check_int("R10 no second done", int'(done), 0);
        repeat (40) @(negedge clk);
        check_int("R10 no late done", int'(done), 0);

        // R11: start in the done cycle, outputs hold meanwhile
        ref_mul(3'd3, 32'h0001_0000, 32'h0000_8000, 1'b0, 16'h0, ch, cl, co);
        issue(3'd3, 32'h0001_0000, 32'h0000_8000, 1'b0, 16'h0);
        wait_done(lat, 1'b0, '0, '0, 1'b0, hb);
        check_res("R11 first result", ch, cl, co);
        ref_mul(3'd0, 32'hFFFF_FFFF, 32'h0000_0002, 1'b0, 16'h0, eh, el, eo);
        issue(3'd0, 32'hFFFF_FFFF, 32'h0000_0002, 1'b0, 16'h0);
        wait_done(lat, 1'b1, ch, cl, co, hb);
        check_int("R11 outputs held until next done", int'(hb), 0);
        check_int("R11 back-to-back latency", lat, LATENCY);
        check_res("R11 second result", eh, el, eo);
        @(negedge clk);

        // Constrained random
        for (int i = 0; i < 160; i++) begin
            logic [2:0]  m;
            logic        ui;
            m  = 3'($urandom % 8);
            ui = ($urandom % 4) == 0;
            run_op(m, pick(), pick(), ui, 16'($urandom));
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule